// File: doc/BRIEF.md
# Oscillator Failure Guard

This block watches an external oscillator and keeps the system clocked when that oscillator stops. All of its logic runs from a free-running internal reference clock. The external clock is brought into that domain through a synchronizer, and its rising edges are detected there. While monitoring is enabled and the start-up timer has expired, a counter measures the reference cycles since the last external edge. If that gap reaches a limit, the block declares a failure. It then moves the clock select to the internal source, raises a sticky failure condition and sets an interrupt flag.

The start-up timer counts external edges after every reset and after every change of the software source-select bit. While it counts, the clock select stays on the internal source, and missing edges are not treated as a failure. When it expires, any failure condition is cleared and the select returns to the external source on its own. The interrupt flag has its own clear input and can be cleared while the failure condition still holds. Only the select signal is driven here. Switching the clock without glitches is left to a separate mux. Monitoring works the same whatever kind of external oscillator is fitted: crystal, resonator, driven clock or RC.

Top module: `osc_fail_guard`

## Requirements
- R1: While rst_ni is low and right after it rises: fail_o=0, irq_o=0, warm_done_o=0 and clk_sel_o=1. On clk_sel_o, 1 means the internal source and 0 means the external source.
- R2: After reset, warm_done_o rises once OST_EDGES (default 1024) rising edges of ext_clk_i have been seen. clk_sel_o then goes to 0, provided fail_o is 0. Before that count is reached, clk_sel_o stays 1.
- R3: When en_i=1 and warm_done_o=1, a gap of MISS_LIMIT (default 32) reference cycles without a synchronized external rising edge sets fail_o=1, clk_sel_o=1 and irq_o=1. This happens no earlier than MISS_LIMIT cycles and no later than MISS_LIMIT+6 cycles after the last external rise.
- R4: While warm_done_o=0, a stopped external clock never sets fail_o, however long it stays stopped.
- R5: While en_i=0, a stopped external clock never sets fail_o. Once en_i returns to 1, detection resumes.
- R6: fail_o is sticky. It stays 1, with clk_sel_o=1, even after the external clock runs again, until the next restart of the start-up timer completes.
- R7: A change of src_sel_i, in either direction, restarts the start-up timer: warm_done_o goes to 0 on the next cycle. When OST_EDGES further edges have been counted, fail_o clears and clk_sel_o returns to 0.
- R8: A one-cycle pulse on flag_clr_i clears irq_o and leaves fail_o unchanged. A failure detected in the same cycle wins over the clear.
- R9: Asserting rst_ni clears fail_o and irq_o and restarts the start-up timer.
- R10: An external clock whose period is shorter than MISS_LIMIT reference cycles, at any duty cycle that the synchronizer can resolve, never sets fail_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk_i | input | 1 | Internal reference clock; all state is in this domain |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_clk_i | input | 1 | External oscillator being watched (asynchronous) |
| en_i | input | 1 | Monitoring enable (configuration bit) |
| src_sel_i | input | 1 | Software source-select bit; any change restarts the start-up timer |
| flag_clr_i | input | 1 | Clears the interrupt flag |
| clk_sel_o | output | 1 | Clock select: 1 internal, 0 external |
| fail_o | output | 1 | Sticky fail-safe condition |
| irq_o | output | 1 | Failure interrupt flag |
| warm_done_o | output | 1 | Start-up timer expired |

## Verification
The hardest state to reach is the exit from a failure. The external clock has to stop after the start-up timer has expired. It then has to resume without clearing the sticky condition. Finally a select toggle has to re-arm the timer, which must count more than a thousand fresh edges before the select returns to the external source. The bench drives an asynchronous external clock with random phase lengths. It stops that clock exactly after a rising edge and times the detection window against that edge. It also toggles the select bit both while the clock runs and while it is stopped, so a restart is seen both with and without a pending failure.

// File: rtl/ofg_pkg.sv
package ofg_pkg;
  typedef enum logic {
    SRC_EXT = 1'b0,
    SRC_INT = 1'b1
  } clk_src_e;

  localparam int DEF_MISS_LIMIT = 32;
  localparam int DEF_OST_EDGES  = 1024;
  localparam int DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/ofg_edge_sync.sv
module ofg_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-1:0], async_i};
  end

  // pipe_q[STAGES] is one beyond the synchronizer, used only for edge detection
  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];

  p_rise_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/ofg_start_timer.sv
module ofg_start_timer #(
  parameter int EDGES = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int W = $clog2(EDGES + 1);
  localparam logic [W-1:0] LAST = W'(EDGES - 1);
  localparam logic [W-1:0] TOP  = W'(EDGES);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else if (restart_i) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else if (tick_i && !done_o) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) done_o <= 1'b1;
    end
  end

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TOP);
  p_done_on_edge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(tick_i));
endmodule

// File: rtl/ofg_miss_detect.sv
module ofg_miss_detect #(
  parameter int LIMIT = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic edge_i,
  output logic timeout_o
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] TOP = W'(LIMIT);

  logic [W-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                gap_q <= '0;
    else if (!arm_i || edge_i)  gap_q <= '0;
    else if (gap_q != TOP)      gap_q <= gap_q + 1'b1;
  end

  assign timeout_o = arm_i && !edge_i && (gap_q == TOP);

  p_no_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q <= TOP);
  p_gap_after_edge_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_i |=> !timeout_o);
endmodule

// File: rtl/osc_fail_guard.sv
module osc_fail_guard
  import ofg_pkg::*;
#(
  parameter int MISS_LIMIT  = DEF_MISS_LIMIT,
  parameter int OST_EDGES   = DEF_OST_EDGES,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic ref_clk_i,
  input  logic rst_ni,
  input  logic ext_clk_i,
  input  logic en_i,
  input  logic src_sel_i,
  input  logic flag_clr_i,
  output logic clk_sel_o,
  output logic fail_o,
  output logic irq_o,
  output logic warm_done_o
);
  logic     ext_rise;
  logic     sel_q, sel_flip;
  logic     warm_q, warm_rise;
  logic     arm, timeout;
  logic     fail_q, irq_q;
  clk_src_e src;

  ofg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (ref_clk_i),
    .rst_ni (rst_ni),
    .async_i(ext_clk_i),
    .rise_o (ext_rise)
  );

  assign sel_flip = src_sel_i ^ sel_q;

  ofg_start_timer #(.EDGES(OST_EDGES)) u_ost (
    .clk_i    (ref_clk_i),
    .rst_ni   (rst_ni),
    .restart_i(sel_flip),
    .tick_i   (ext_rise),
    .done_o   (warm_done_o)
  );

  assign arm = en_i & warm_done_o & ~fail_q;

  ofg_miss_detect #(.LIMIT(MISS_LIMIT)) u_miss (
    .clk_i    (ref_clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (arm),
    .edge_i   (ext_rise),
    .timeout_o(timeout)
  );

  assign warm_rise = warm_done_o & ~warm_q;

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b0;
      warm_q <= 1'b0;
      fail_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      sel_q  <= src_sel_i;
      warm_q <= warm_done_o;
      if (timeout)        fail_q <= 1'b1;
      else if (warm_rise) fail_q <= 1'b0;
      if (timeout)         irq_q <= 1'b1;
      else if (flag_clr_i) irq_q <= 1'b0;
    end
  end

  assign src       = (fail_q || !warm_done_o) ? SRC_INT : SRC_EXT;
  assign clk_sel_o = src;
  assign fail_o    = fail_q;
  assign irq_o     = irq_q;

  p_fail_needs_en_r5: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> $past(en_i));
  p_no_fail_warmup_r4: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> $past(warm_done_o));
  p_int_on_fail_r3: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    fail_o |-> clk_sel_o);
  p_irq_with_fail_r3: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> irq_o);
  p_flip_rearms_r7: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (src_sel_i != sel_q) |=> !warm_done_o);
  p_fail_exit_r6: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $fell(fail_o) |-> (warm_done_o && !$past(warm_done_o, 2)));
  p_irq_clear_r8: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (flag_clr_i && !fail_o && !arm) |=> !irq_o);
endmodule

// File: tb/osc_fail_guard_bench.sv
`timescale 1ns/1ps
module osc_fail_guard_bench;
  localparam int MISS = 32;
  localparam int OSTN = 1024;
  localparam int TCK  = 8;

  logic clk = 1'b0, rst_n = 1'b0, ext = 1'b0;
  logic en = 1'b1, sel = 1'b0, clr = 1'b0;
  logic clk_sel, fail, irq, warm;

  int total = 0, bad = 0;
  int hi_ns = 20, lo_ns = 20;
  bit ext_run = 1'b0;
  int rises = 0;
  longint last_rise = 0;
  bit finished = 1'b0;

  osc_fail_guard #(.MISS_LIMIT(MISS), .OST_EDGES(OSTN)) u_osc_fail_guard (
    .ref_clk_i(clk), .rst_ni(rst_n), .ext_clk_i(ext), .en_i(en),
    .src_sel_i(sel), .flag_clr_i(clr), .clk_sel_o(clk_sel),
    .fail_o(fail), .irq_o(irq), .warm_done_o(warm)
  );

  always #4 clk = ~clk;

  // asynchronous external oscillator; stops holding its level
  initial begin
    forever begin
      wait (ext_run);
      if (ext) begin
        ext = 1'b0;
        #(lo_ns);
        continue;
      end
      ext = 1'b1;
      rises++;
      last_rise = $time;
      #(hi_ns);
      if (ext_run) begin
        ext = 1'b0;
        #(lo_ns);
      end
    end
  end

  function automatic bit exp_sel(bit failed, bit warm_ok);
    return failed || !warm_ok;
  endfunction

  function automatic int early_bound();
    return MISS - 1;
  endfunction

  function automatic int late_bound();
    return MISS + 6;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stop_ext();
    ext_run = 1'b0;
    #(hi_ns + lo_ns + 2);
    @(negedge clk);
  endtask

  task automatic wait_since_rise(int cycles);
    longint tgt;
    tgt = last_rise + longint'(cycles) * TCK;
    if ($time < tgt) #(tgt - $time);
    @(negedge clk);
  endtask

  task automatic run_edges(int n);
    int start;
    start = rises;
    ext_run = 1'b1;
    wait (rises >= start + n);
    @(negedge clk);
  endtask

  task automatic check_state(string req, bit e_fail, bit e_warm);
    chk(fail == e_fail, {req, " fail"}, int'(fail), int'(e_fail));
    chk(warm == e_warm, {req, " warm"}, int'(warm), int'(e_warm));
    chk(clk_sel == exp_sel(e_fail, e_warm), {req, " sel"}, int'(clk_sel),
        int'(exp_sel(e_fail, e_warm)));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * TCK);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    cyc(5);
    // R1 reset state
    check_state("R1", 1'b0, 1'b0);
    chk(irq == 1'b0, "R1 irq", int'(irq), 0);
    rst_n = 1'b1;
    cyc(2);
    check_state("R1 post", 1'b0, 1'b0);

    // R2 start-up count
    run_edges(OSTN - 24);
    cyc(2);
    check_state("R2 early", 1'b0, 1'b0);
    run_edges(24);
    cyc(6);
    check_state("R2 done", 1'b0, 1'b1);

    // R10 random periods and duty cycles, plus both duty extremes
    for (int i = 0; i < 8; i++) begin
      if (i == 0)      begin hi_ns = 17; lo_ns = 76; end
      else if (i == 1) begin hi_ns = 76; lo_ns = 17; end
      else begin
        hi_ns = $urandom_range(17, 76);
        lo_ns = $urandom_range(17, 76);
      end
      cyc(300);
      check_state("R10", 1'b0, 1'b1);
    end
    hi_ns = 20; lo_ns = 20;

    // R3 detection window from the last rise
    stop_ext();
    wait_since_rise(early_bound());
    chk(fail == 1'b0, "R3 too early", int'(fail), 0);
    wait_since_rise(late_bound());
    check_state("R3", 1'b1, 1'b1);
    chk(irq == 1'b1, "R3 irq", int'(irq), 1);

    // R6 sticky while clock runs again
    ext_run = 1'b1;
    cyc(200);
    check_state("R6", 1'b1, 1'b1);

    // R8 flag clear independent of fail condition
    clr = 1'b1;
    cyc(1);
    clr = 1'b0;
    cyc(2);
    chk(irq == 1'b0, "R8 irq", int'(irq), 0);
    chk(fail == 1'b1, "R8 fail", int'(fail), 1);

    // R7 toggle with pending failure, clock running
    sel = 1'b1;
    cyc(3);
    check_state("R7 rearm", 1'b1, 1'b0);
    run_edges(OSTN - 24);
    cyc(2);
    check_state("R7 counting", 1'b1, 1'b0);
    run_edges(30);
    cyc(6);
    check_state("R7 exit", 1'b0, 1'b1);

    // R7 toggle in other direction, then R4 no detection during warm-up
    sel = 1'b0;
    stop_ext();
    cyc(300);
    check_state("R4 warmup", 1'b0, 1'b0);
    run_edges(OSTN);
    cyc(6);
    check_state("R7 back", 1'b0, 1'b1);

    // R5 disabled monitor ignores a stopped clock
    en = 1'b0;
    stop_ext();
    cyc(100);
    check_state("R5 off", 1'b0, 1'b1);
    chk(irq == 1'b0, "R5 irq", int'(irq), 0);
    en = 1'b1;
    cyc(late_bound() + 2);
    check_state("R5 on", 1'b1, 1'b1);

    // R9 reset clears the condition and restarts warm-up
    rst_n = 1'b0;
    cyc(2);
    check_state("R9", 1'b0, 1'b0);
    chk(irq == 1'b0, "R9 irq", int'(irq), 0);
    rst_n = 1'b1;
    cyc(100);
    check_state("R9 R4", 1'b0, 1'b0);
    run_edges(OSTN);
    cyc(6);
    check_state("R9 done", 1'b0, 1'b1);

    finish_run();
  end
endmodule